// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It takes one read or write request at a time on a valid/ready handshake. A request carries a bank, a row, a column, a burst-length code and an auto-precharge flag. The block turns each request into the commands the memory needs and drives them from a register, one command per rising clock edge. It keeps a record of the row that is open in each bank. A request that hits the open row goes straight to the access. A request to an idle bank is given an activate first. A request to a bank that has a different row open is given a precharge, then an activate, then the access.

Every minimum gap is a parameter counted in clock cycles and is enforced by a down-counter for each bank. The gaps are activate-to-access, precharge-to-activate and refresh cycle time. A burst also holds off the next command until its data phase is over. For reads, the block flags the rising or falling half-cycle in which each data beat is due. The CAS latency is a parameter in half cycles, so a latency of 2.5 is exact.

A free-running timer, derived from the clock frequency and a 7.8 µs target, raises a refresh request. That request outranks new traffic. The block closes every open bank and then issues Auto Refresh. Because the timer never waits for the refresh to go out, a late refresh does not push back the ones that follow.

Top module: `ddr_cmd_seq`

## Requirements
- R1: Reset state. After reset, `cmd` is NOP (0), `req_ready` is 1, `rd_rise` and `rd_fall` are 0, and every bank is idle. This holds even if banks were open before reset, so the first access to any bank is given an activate.
- R2: Idle bank. A request to an idle bank produces an activate with `cmd_addr` = row, then a read or write with `cmd_addr` = column. Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5.
- R3: Row hit. A request whose row equals the open row of its bank produces only the read or write.
- R4: Row conflict. A request to a bank with another row open produces a precharge to that bank, then an activate, then the access.
- R5: Minimum gaps on the command port. The gap from an activate to an access of the same bank is at least T_RCD cycles. The gap from a precharge to the next activate of that bank is at least T_RP cycles. The gap from a refresh to any later command is at least T_RFC cycles.
- R6: Read data window. Burst codes are 0 for 2 beats, 1 for 4 beats, and 2 or 3 for 8 beats. Take the rising edge of the cycle that carries RD as half-slot 0. The data beats then occupy half-slots CL_HALF to CL_HALF+beats-1. An even slot 2k raises `rd_rise` in cycle k, and an odd slot 2k+1 raises `rd_fall` in cycle k. At all other times both are 0.
- R7: Auto precharge. An access with `req_ap`=1 drives `cmd_ap`=1. The bank is then idle, so the next request to it is given an activate without a precharge. That activate comes no sooner than beats/2+T_RP cycles after the access.
- R8: Refresh. While a refresh is pending, `req_ready` is 0. Each open bank gets a precharge, lowest index first, and then REF is issued. After REF all banks are idle.
- R9: Refresh pacing. The refresh timer has a period of REF_CYCLES = CLK_MHZ*REF_NS/1000 cycles and runs without regard to when REF goes out. With no traffic, consecutive REFs are exactly REF_CYCLES apart. A delayed REF is followed by a gap shorter than REF_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_blen | input | 2 | Burst code (2, 4, 8, 8 beats) |
| req_ap | input | 1 | Close the row after this burst |
| cmd | output | 3 | Command code |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR |
| cmd_ap | output | 1 | Auto-precharge flag with RD/WR |
| rd_rise | output | 1 | Read beat due in the first half of this cycle |
| rd_fall | output | 1 | Read beat due in the second half of this cycle |

## Verification
The hardest case to reach from the ports is a refresh that falls due while several banks hold open rows. That case also needs the precharge-before-refresh order and the refresh pacing to be visible. The stimulus gets there with a reduced clock-frequency parameter. A table of requests first leaves all four banks open with different rows. The bench then waits for the timer to expire and checks the PRE order and the blocked handshake. After that it lets the timer run through two more intervals with the banks idle, to compare a delayed refresh with an undelayed one.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_REF   = 2'd2
  } seq_st_e;

  // burst code to beat count
  function automatic logic [3:0] beats_of(input logic [1:0] code);
    case (code)
      2'd0:    beats_of = 4'd2;
      2'd1:    beats_of = 4'd4;
      default: beats_of = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/seq_bank_state.sv
module seq_bank_state
  import ddr_seq_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int TW    = 6,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 10,
  localparam int BW   = $clog2(NB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cmd_e                     iss_cmd,
  input  logic [BW-1:0]            iss_bank,
  input  logic [ROW_W-1:0]         iss_row,
  input  logic                     iss_ap,
  input  logic [TW-1:0]            ap_hold,
  output logic [NB-1:0]            open_o,
  output logic [NB-1:0][ROW_W-1:0] row_o,
  output logic [NB-1:0]            zero_o
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_q, open_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic [TW-1:0]    tmr_q, tmr_n;
    logic             here;

    assign here = (iss_bank == BW'(b));

    always_comb begin
      open_n = open_q;
      row_n  = row_q;
      tmr_n  = (tmr_q != '0) ? tmr_q - 1'b1 : '0;
      if (iss_cmd == CMD_REF) begin
        tmr_n = TW'(T_RFC - 1);
      end else if (here) begin
        case (iss_cmd)
          CMD_ACT: begin
            open_n = 1'b1;
            row_n  = iss_row;
            tmr_n  = TW'(T_RCD - 1);
          end
          CMD_PRE: begin
            open_n = 1'b0;
            tmr_n  = TW'(T_RP - 1);
          end
          CMD_RD, CMD_WR: begin
            if (iss_ap) begin
              open_n = 1'b0;
              tmr_n  = ap_hold;
            end
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
        tmr_q  <= '0;
      end else begin
        open_q <= open_n;
        row_q  <= row_n;
        tmr_q  <= tmr_n;
      end
    end

    assign open_o[b] = open_q;
    assign row_o[b]  = row_q;
    assign zero_o[b] = (tmr_q == '0);

    // R2
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_cmd == CMD_ACT && here) |-> (!open_q && tmr_q == '0));
    // R5
    access_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((iss_cmd == CMD_RD || iss_cmd == CMD_WR) && here) |-> (open_q && tmr_q == '0));
    // R4
    pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_cmd == CMD_PRE && here) |-> (open_q && tmr_q == '0));
    // R8
    ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_cmd == CMD_REF) |-> (!open_q && tmr_q == '0));
  end

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int REF_CYCLES = 1037,
  localparam int CW = $clog2(REF_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic pend_o
);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n;
  logic          wrap;

  assign wrap = (cnt_q == '0);

  always_comb begin
    cnt_n  = wrap ? CW'(REF_CYCLES - 1) : cnt_q - 1'b1;
    pend_n = pend_q;
    if (ref_done) pend_n = 1'b0;
    if (wrap)     pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(REF_CYCLES - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

  // R9
  ref_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> pend_q);

endmodule

// File: rtl/seq_rd_window.sv
module seq_rd_window #(
  parameter int CL_HALF = 5,
  parameter int CW      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] start_beats,
  output logic       rise_o,
  output logic       fall_o
);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [3:0]    beats_q, beats_n;
  int            h, last;

  always_comb begin
    h      = 2 * int'(cnt_q);
    last   = CL_HALF + int'(beats_q) - 1;
    rise_o = act_q && (h >= CL_HALF) && (h <= last);
    fall_o = act_q && (h + 1 >= CL_HALF) && (h + 1 <= last);
    act_n   = act_q;
    cnt_n   = cnt_q;
    beats_n = beats_q;
    if (start) begin
      act_n   = 1'b1;
      cnt_n   = '0;
      beats_n = start_beats;
    end else if (act_q) begin
      cnt_n = cnt_q + 1'b1;
      if (h + 1 >= last) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      beats_q <= '0;
    end else begin
      act_q   <= act_n;
      cnt_q   <= cnt_n;
      beats_q <= beats_n;
    end
  end

  // R6
  rd_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!act_q || (h + 1 >= last)));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int CLK_MHZ = 133,
  parameter int REF_NS  = 7800,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int CL_HALF = 5,
  localparam int NB     = 4,
  localparam int BW     = $clog2(NB),
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int TW     = $clog2(T_RFC + T_RP + 16),
  localparam int UW     = $clog2(CL_HALF + 16),
  localparam int REF_CYCLES = CLK_MHZ * REF_NS / 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [1:0]       req_blen,
  input  logic             req_ap,
  output logic [2:0]       cmd,
  output logic [BW-1:0]    cmd_bank,
  output logic [AW-1:0]    cmd_addr,
  output logic             cmd_ap,
  output logic             rd_rise,
  output logic             rd_fall
);

  seq_st_e st_q, st_n;

  logic             h_wr_q, h_ap_q;
  logic [BW-1:0]    h_bank_q;
  logic [ROW_W-1:0] h_row_q;
  logic [COL_W-1:0] h_col_q;
  logic [1:0]       h_bl_q;
  logic             cap_en;

  logic [UW-1:0]    busy_q, busy_n;

  cmd_e             iss_cmd;
  logic [BW-1:0]    iss_bank;
  logic [AW-1:0]    iss_addr;
  logic             iss_ap;

  cmd_e             cmd_q;
  logic [BW-1:0]    cmd_bank_q;
  logic [AW-1:0]    cmd_addr_q;
  logic             cmd_ap_q;

  logic [NB-1:0]            open_w, zero_w;
  logic [NB-1:0][ROW_W-1:0] row_w;
  logic                     ref_pend;
  logic [3:0]               h_beats;
  logic [TW-1:0]            ap_hold;
  logic [BW-1:0]            low_open;

  assign h_beats = beats_of(h_bl_q);
  assign ap_hold = TW'(T_RP - 1) + TW'(h_beats >> 1);

  always_comb begin
    low_open = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (open_w[i]) low_open = BW'(i);
    end
  end

  always_comb begin
    st_n      = st_q;
    req_ready = (st_q == ST_IDLE) && !ref_pend;
    cap_en    = 1'b0;
    iss_cmd   = CMD_NOP;
    iss_bank  = h_bank_q;
    iss_addr  = '0;
    iss_ap    = 1'b0;
    busy_n    = (busy_q != '0) ? busy_q - 1'b1 : '0;
    case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_n = ST_REF;
        end else if (req_valid) begin
          cap_en = 1'b1;
          st_n   = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (busy_q == '0 && zero_w[h_bank_q]) begin
          if (open_w[h_bank_q] && row_w[h_bank_q] == h_row_q) begin
            iss_cmd  = h_wr_q ? CMD_WR : CMD_RD;
            iss_addr = AW'(h_col_q);
            iss_ap   = h_ap_q;
            busy_n   = h_wr_q ? UW'(h_beats >> 1)
                              : UW'((CL_HALF + int'(h_beats) - 1) / 2);
            st_n     = ST_IDLE;
          end else if (open_w[h_bank_q]) begin
            iss_cmd = CMD_PRE;
          end else begin
            iss_cmd  = CMD_ACT;
            iss_addr = AW'(h_row_q);
          end
        end
      end
      ST_REF: begin
        if (busy_q == '0) begin
          if (|open_w) begin
            iss_bank = low_open;
            if (zero_w[low_open]) iss_cmd = CMD_PRE;
          end else if (&zero_w) begin
            iss_cmd  = CMD_REF;
            iss_bank = '0;
            st_n     = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      busy_q     <= '0;
      cmd_q      <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
      cmd_ap_q   <= 1'b0;
    end else begin
      st_q       <= st_n;
      busy_q     <= busy_n;
      cmd_q      <= iss_cmd;
      cmd_bank_q <= iss_bank;
      cmd_addr_q <= iss_addr;
      cmd_ap_q   <= iss_ap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_wr_q   <= 1'b0;
      h_ap_q   <= 1'b0;
      h_bank_q <= '0;
      h_row_q  <= '0;
      h_col_q  <= '0;
      h_bl_q   <= '0;
    end else if (cap_en) begin
      h_wr_q   <= req_write;
      h_ap_q   <= req_ap;
      h_bank_q <= req_bank;
      h_row_q  <= req_row;
      h_col_q  <= req_col;
      h_bl_q   <= req_blen;
    end
  end

  seq_bank_state #(
    .NB(NB), .ROW_W(ROW_W), .TW(TW),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .iss_cmd(iss_cmd), .iss_bank(iss_bank), .iss_row(h_row_q),
    .iss_ap(iss_ap), .ap_hold(ap_hold),
    .open_o(open_w), .row_o(row_w), .zero_o(zero_w)
  );

  seq_refresh_timer #(.REF_CYCLES(REF_CYCLES)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .ref_done(iss_cmd == CMD_REF),
    .pend_o(ref_pend)
  );

  seq_rd_window #(.CL_HALF(CL_HALF), .CW(UW)) u_rdw (
    .clk(clk), .rst_n(rst_n),
    .start(iss_cmd == CMD_RD),
    .start_beats(h_beats),
    .rise_o(rd_rise), .fall_o(rd_fall)
  );

  assign cmd      = cmd_q;
  assign cmd_bank = cmd_bank_q;
  assign cmd_addr = cmd_addr_q;
  assign cmd_ap   = cmd_ap_q;

  // R3
  hit_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERVE && open_w[h_bank_q] && row_w[h_bank_q] == h_row_q)
      |-> (iss_cmd != CMD_ACT && iss_cmd != CMD_PRE));

endmodule

// File: tb/test_ddr_cmd_seq.sv
module test_ddr_cmd_seq;

  localparam int ROW_W = 13, COL_W = 10, AW = 13;
  localparam int CLK_MHZ = 50, REF_NS = 7800;
  localparam int T_RCD = 3, T_RP = 2, T_RFC = 6, CL_HALF = 5;
  localparam int REF_CYCLES = CLK_MHZ * REF_NS / 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_ap;
  logic [1:0] req_bank, req_blen, cmd_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [2:0] cmd;
  logic [AW-1:0] cmd_addr;
  logic cmd_ap, rd_rise, rd_fall;

  always #2 clk = ~clk;

  ddr_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CLK_MHZ(CLK_MHZ), .REF_NS(REF_NS),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .CL_HALF(CL_HALF)
  ) i_ddr_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_blen(req_blen), .req_ap(req_ap),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
    .rd_rise(rd_rise), .rd_fall(rd_fall)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int cur_beats = 2;

  int lg_cmd[64], lg_bank[64], lg_addr[64], lg_ap[64], lg_cyc[64], lg_rdy[64];
  int n_log = 0;
  int ref_cyc[8];
  int n_ref = 0;

  bit mopen[4];
  int act_cyc[4], act_ok[4];
  int ref_ok;
  bit rd_trk;
  int rd_t, rd_b;

  // write, bank, row, col, burst code, ap, expected kind (0 hit, 1 idle, 2 conflict)
  localparam logic [30:0] VEC [10] = '{
    {1'b0, 2'd0, 13'd5,   10'd8,  2'd1, 1'b0, 2'd1},
    {1'b1, 2'd0, 13'd5,   10'd16, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd1, 13'd9,   10'd3,  2'd2, 1'b0, 2'd1},
    {1'b0, 2'd0, 13'd7,   10'd0,  2'd1, 1'b0, 2'd2},
    {1'b1, 2'd1, 13'd9,   10'd4,  2'd1, 1'b1, 2'd0},
    {1'b0, 2'd1, 13'd9,   10'd5,  2'd0, 1'b0, 2'd1},
    {1'b0, 2'd2, 13'd1,   10'd1,  2'd3, 1'b0, 2'd1},
    {1'b0, 2'd2, 13'd2,   10'd2,  2'd1, 1'b1, 2'd2},
    {1'b0, 2'd2, 13'd2,   10'd2,  2'd0, 1'b0, 2'd1},
    {1'b1, 2'd3, 13'd100, 10'd1,  2'd0, 1'b0, 2'd1}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic clear_model();
    for (int b = 0; b < 4; b++) begin
      mopen[b] = 0; act_cyc[b] = -100; act_ok[b] = 0;
    end
    ref_ok = 0;
    rd_trk = 0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // command log, gap model and read-window model
  always @(negedge clk) begin
    if (!rst_n) begin
      clear_model();
    end else begin
      if (cmd != 3'd0) begin
        if (n_log < 64) begin
          lg_cmd[n_log] = cmd; lg_bank[n_log] = cmd_bank; lg_addr[n_log] = cmd_addr;
          lg_ap[n_log] = cmd_ap; lg_cyc[n_log] = cyc; lg_rdy[n_log] = req_ready;
          n_log++;
        end
        if (cmd != 3'd5) check(cyc >= ref_ok, "R5 refresh-to-command cycle", cyc, ref_ok);
        case (cmd)
          3'd1: begin
            check(!mopen[cmd_bank], "R2 activate to open bank", 1, 0);
            check(cyc >= act_ok[cmd_bank], "R5/R7 activate too early, cycle", cyc, act_ok[cmd_bank]);
            mopen[cmd_bank] = 1; act_cyc[cmd_bank] = cyc;
          end
          3'd2, 3'd3: begin
            check(mopen[cmd_bank], "R2 access to idle bank", 0, 1);
            check(cyc - act_cyc[cmd_bank] >= T_RCD, "R5 activate-to-access gap",
                  cyc - act_cyc[cmd_bank], T_RCD);
            if (cmd_ap) begin
              mopen[cmd_bank] = 0;
              act_ok[cmd_bank] = cyc + cur_beats / 2 + T_RP;
            end
            if (cmd == 3'd2) begin
              rd_trk = 1; rd_t = cyc; rd_b = cur_beats;
            end
          end
          3'd4: begin
            check(mopen[cmd_bank], "R4 precharge to idle bank", 0, 1);
            mopen[cmd_bank] = 0; act_ok[cmd_bank] = cyc + T_RP;
          end
          3'd5: begin
            for (int b = 0; b < 4; b++) begin
              check(!mopen[b], "R8 refresh with open bank", b, -1);
              act_ok[b] = cyc + T_RFC;
            end
            ref_ok = cyc + T_RFC;
            if (n_ref < 8) ref_cyc[n_ref] = cyc;
            n_ref++;
          end
          default: check(0, "R2 illegal command code", cmd, 0);
        endcase
      end
      if (rd_trk) begin
        int n, h;
        bit er, ef;
        n = cyc - rd_t;
        h = 2 * n;
        er = (h >= CL_HALF) && (h < CL_HALF + rd_b);
        ef = (h + 1 >= CL_HALF) && (h + 1 < CL_HALF + rd_b);
        if (n <= 8) begin
          check(rd_rise == er, "R6 rd_rise", rd_rise, er);
          check(rd_fall == ef, "R6 rd_fall", rd_fall, ef);
        end else rd_trk = 0;
      end else if (rd_rise || rd_fall) begin
        check(0, "R6 read strobe outside window", 1, 0);
      end
    end
  end

  task automatic submit(input bit wr, input int bank, input int row, input int col,
                        input int bl, input bit ap);
    @(negedge clk);
    req_write = wr; req_bank = 2'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
    req_blen = 2'(bl); req_ap = ap; req_valid = 1'b1;
    cur_beats = (bl == 0) ? 2 : (bl == 1) ? 4 : 8;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 60 && n_log < target; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_ref(input int target);
    for (int i = 0; i < 1200 && n_ref < target; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base, exp_n, idx;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 0; req_bank = 0; req_row = 0;
    req_col = 0; req_blen = 0; req_ap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd == 3'd0, "R1 cmd after reset", cmd, 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(!rd_rise && !rd_fall, "R1 read strobes after reset", {rd_rise, rd_fall}, 0);

    // table of requests (R2 R3 R4 R6 R7)
    for (int v = 0; v < 10; v++) begin
      logic [30:0] e;
      int kind, acc;
      e = VEC[v];
      kind = int'(e[1:0]);
      base = n_log;
      exp_n = kind + 1;
      submit(e[30], int'(e[29:28]), int'(e[27:15]), int'(e[14:5]), int'(e[4:3]), e[2]);
      wait_log(base + exp_n);
      check(n_log - base == exp_n, kind == 0 ? "R3 command count" :
            kind == 1 ? "R2 command count" : "R4 command count", n_log - base, exp_n);
      idx = base;
      if (kind == 2) begin
        check(lg_cmd[idx] == 4 && lg_bank[idx] == int'(e[29:28]), "R4 precharge first",
              lg_cmd[idx], 4);
        idx++;
      end
      if (kind >= 1) begin
        check(lg_cmd[idx] == 1 && lg_bank[idx] == int'(e[29:28]) && lg_addr[idx] == int'(e[27:15]),
              "R2 activate with row", lg_addr[idx], int'(e[27:15]));
        idx++;
      end
      acc = e[30] ? 3 : 2;
      check(lg_cmd[idx] == acc && lg_bank[idx] == int'(e[29:28]) && lg_addr[idx] == int'(e[14:5]),
            kind == 0 ? "R3 access on hit" : "R2 access with column", lg_cmd[idx], acc);
      check(lg_ap[idx] == int'(e[2]), "R7 cmd_ap on access", lg_ap[idx], int'(e[2]));
    end

    // refresh with all four banks open (R8)
    base = n_log;
    wait_ref(1);
    check(n_ref == 1, "R8 refresh issued", n_ref, 1);
    check(n_log - base == 5, "R8 precharges plus refresh", n_log - base, 5);
    for (int b = 0; b < 4; b++)
      check(lg_cmd[base + b] == 4 && lg_bank[base + b] == b, "R8 precharge order",
            lg_bank[base + b], b);
    check(lg_cmd[base + 4] == 5, "R8 refresh after precharges", lg_cmd[base + 4], 5);
    check(lg_rdy[base] == 0, "R8 req_ready low while refresh pending", lg_rdy[base], 0);

    // after refresh every bank is idle (R8)
    base = n_log;
    submit(1'b0, 0, 7, 3, 0, 1'b1);
    wait_log(base + 2);
    check(lg_cmd[base] == 1 && lg_bank[base] == 0, "R8 bank idle after refresh", lg_cmd[base], 1);

    // pacing (R9)
    wait_ref(3);
    check(n_ref >= 3, "R9 later refreshes issued", n_ref, 3);
    check(ref_cyc[2] - ref_cyc[1] == REF_CYCLES, "R9 idle refresh interval",
          ref_cyc[2] - ref_cyc[1], REF_CYCLES);
    check(ref_cyc[1] - ref_cyc[0] < REF_CYCLES, "R9 delayed refresh does not drift",
          ref_cyc[1] - ref_cyc[0], REF_CYCLES - 1);

    // reset while a bank is open (R1)
    base = n_log;
    submit(1'b1, 1, 3, 0, 0, 1'b0);
    wait_log(base + 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(cmd == 3'd0 && req_ready, "R1 state after mid-run reset", cmd, 0);
    base = n_log;
    submit(1'b1, 1, 3, 0, 0, 1'b0);
    wait_log(base + 2);
    check(lg_cmd[base] == 1, "R1 bank idle after reset", lg_cmd[base], 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule